// File: doc/BRIEF.md
# Downward Stack Sequencer

This block keeps the stack pointer, frame pointer and instruction pointer of a 32-bit datapath. It carries out the stack-related commands against a single memory port. The stack grows toward lower byte addresses in 4-byte steps. A push stores at the lowered pointer. A pop reads at the current pointer and then raises it. Call, return, frame setup and frame teardown are built from these same two moves. Each one also updates the instruction pointer or the frame pointer.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a command is in flight, the upstream stage must hold further commands.

The memory side is also valid/ready. The block raises `mem_req` and holds the address, direction and write data steady until the memory answers with `mem_ack`. Read data must be presented in the same cycle as `mem_ack`. The memory may stall for any number of cycles. The pointer registers change only on the edge where the access completes. One cycle after that edge, `done` pulses once with the new pointer values already visible.

Top module: `stk_engine`

## Requirements
- R1: After reset, `sp` and `bp` both equal the parameter `TOS`, `ip` equals the parameter `RST_VEC`, `busy` and `done` are 0, `cmd_ready` is 1, and `mem_req` is 0.
- R2: A command is accepted on an edge with `cmd_valid` and `cmd_ready` both high. From that edge, `busy` is 1 and `cmd_ready` is 0 until the access completes. `done` is high for exactly one cycle, starting the cycle after the completing edge. With no memory stall, `done` is seen two edges after acceptance.
- R3: Each command makes at most one memory access. `mem_req` is held, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack`. Every address has bits [1:0] equal to 0.
- R4: Push (`cmd_op`=0) writes `cmd_opnd` at `sp-4`. Afterwards `sp` equals that address.
- R5: Pop (`cmd_op`=1) reads the word at `sp` into `pop_data` and then raises `sp` by 4. Pushes and pops behave last-in first-out.
- R6: Call (`cmd_op`=2) writes `cmd_ip` at `sp-4`, lowers `sp` by 4, and loads `ip` with `cmd_opnd`.
- R7: Return (`cmd_op`=3) reads the word at `sp` into `ip` and `pop_data`, and raises `sp` by 4.
- R8: Frame setup (`cmd_op`=4) writes the old `bp` at `sp-4` and then sets both `sp` and `bp` to `sp-4`. Afterwards the word at `bp` is the previous frame pointer, and the word at `bp+4` is the return address pushed by the preceding call.
- R9: Frame teardown (`cmd_op`=5) reads the word at `bp` into `bp` and `pop_data`, and sets `sp` to the old `bp` plus 4.
- R10: While memory withholds `mem_ack`, `sp`, `bp` and `ip` keep their values. Command latency is the stall count plus one cycle.
- R11: Codes 6 and 7 are accepted and give a `done` pulse on the following cycle. They make no memory access and leave `sp`, `bp`, `ip` and `pop_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 call, 3 return, 4 frame setup, 5 frame teardown) |
| cmd_opnd | input | 32 | Push value or call target |
| cmd_ip | input | 32 | Current instruction pointer, pushed by call |
| sp | output | 32 | Stack pointer |
| bp | output | 32 | Frame pointer |
| ip | output | 32 | Instruction pointer |
| pop_data | output | 32 | Last word read from the stack |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory accepts/finishes the access |

## Verification
The bench builds a full frame (call, frame setup, local push, frame teardown, return) and checks that the saved frame pointer and the return address land 4 bytes apart. A design that ordered the pointer move and the store wrongly would put the return address at the wrong offset, or return to the wrong place. A stalled access checks that no pointer moves before `mem_ack`. A design that updates early would show a shifted `sp` while `busy` is still high. Undefined codes are checked for a stray memory access or a changed pointer. Back-to-back pushes and pops check last-in order: an off-by-one step in a design would return the wrong word.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_ENTER = 3'd4,
    OP_LEAVE = 3'd5
  } stk_op_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACCESS = 1'b1} stk_st_e;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_ENTER);
  endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_opnd,
  input  logic [DW-1:0] cmd_ip,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] bp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          done,
  output logic          sp_ld,
  output logic [DW-1:0] sp_nxt,
  output logic          bp_ld,
  output logic [DW-1:0] bp_nxt,
  output logic          ip_ld,
  output logic [DW-1:0] ip_nxt,
  output logic          res_ld,
  output logic [DW-1:0] res_nxt
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  stk_st_e       st;
  logic [2:0]    op_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] ip_q;
  logic          done_q;
  logic          accept;
  logic          fin;
  logic [DW-1:0] below_sp;

  assign accept    = cmd_valid && (st == ST_IDLE);
  assign fin       = (st == ST_ACCESS) && mem_ack;
  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st == ST_ACCESS);
  assign done      = done_q;
  assign below_sp  = sp - STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= '0;
      opnd_q <= '0;
      ip_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin || (accept && !op_known(cmd_op));
      if (accept) begin
        op_q   <= cmd_op;
        opnd_q <= cmd_opnd;
        ip_q   <= cmd_ip;
        st     <= op_known(cmd_op) ? ST_ACCESS : ST_IDLE;
      end else if (fin) begin
        st <= ST_IDLE;
      end
    end
  end

  always_comb begin
    mem_req  = (st == ST_ACCESS);
    mem_we   = op_writes(op_q);
    if (op_q == OP_LEAVE)  mem_addr = bp;
    else if (mem_we)       mem_addr = below_sp;
    else                   mem_addr = sp;
    if (op_q == OP_CALL)       mem_wdata = ip_q;
    else if (op_q == OP_ENTER) mem_wdata = bp;
    else                       mem_wdata = opnd_q;

    sp_ld   = fin;
    sp_nxt  = mem_we ? below_sp : mem_addr + STEP;
    bp_ld   = fin && ((op_q == OP_ENTER) || (op_q == OP_LEAVE));
    bp_nxt  = (op_q == OP_ENTER) ? below_sp : mem_rdata;
    ip_ld   = fin && ((op_q == OP_CALL) || (op_q == OP_RET));
    ip_nxt  = (op_q == OP_CALL) ? opnd_q : mem_rdata;
    res_ld  = fin && !mem_we;
    res_nxt = mem_rdata;
  end
endmodule

// File: rtl/stk_ptrs.sv
module stk_ptrs #(
  parameter int              DW      = 32,
  parameter logic [DW-1:0]   TOS     = 32'h0000_1000,
  parameter logic [DW-1:0]   RST_VEC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_ld,
  input  logic [DW-1:0] sp_nxt,
  input  logic          bp_ld,
  input  logic [DW-1:0] bp_nxt,
  input  logic          ip_ld,
  input  logic [DW-1:0] ip_nxt,
  input  logic          res_ld,
  input  logic [DW-1:0] res_nxt,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] bp,
  output logic [DW-1:0] ip,
  output logic [DW-1:0] res
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= TOS;
      bp  <= TOS;
      ip  <= RST_VEC;
      res <= '0;
    end else begin
      if (sp_ld)  sp  <= sp_nxt;
      if (bp_ld)  bp  <= bp_nxt;
      if (ip_ld)  ip  <= ip_nxt;
      if (res_ld) res <= res_nxt;
    end
  end
endmodule

// File: rtl/stk_engine.sv
module stk_engine #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] TOS     = 32'h0000_1000,
  parameter logic [DW-1:0] RST_VEC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_opnd,
  input  logic [DW-1:0] cmd_ip,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] bp,
  output logic [DW-1:0] ip,
  output logic [DW-1:0] pop_data,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  logic          sp_ld, bp_ld, ip_ld, res_ld;
  logic [DW-1:0] sp_nxt, bp_nxt, ip_nxt, res_nxt;

  stk_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_opnd(cmd_opnd), .cmd_ip(cmd_ip),
    .sp(sp), .bp(bp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .done(done),
    .sp_ld(sp_ld), .sp_nxt(sp_nxt), .bp_ld(bp_ld), .bp_nxt(bp_nxt),
    .ip_ld(ip_ld), .ip_nxt(ip_nxt), .res_ld(res_ld), .res_nxt(res_nxt)
  );

  stk_ptrs #(.DW(DW), .TOS(TOS), .RST_VEC(RST_VEC)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .sp_ld(sp_ld), .sp_nxt(sp_nxt), .bp_ld(bp_ld), .bp_nxt(bp_nxt),
    .ip_ld(ip_ld), .ip_nxt(ip_nxt), .res_ld(res_ld), .res_nxt(res_nxt),
    .sp(sp), .bp(bp), .ip(ip), .res(pop_data)
  );
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic [DW-1:0] sp,
  input logic [DW-1:0] bp,
  input logic [DW-1:0] ip,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  a_r2_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> done);

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  a_r4_write_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> (sp == $past(mem_addr)));

  a_r5_read_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (sp == $past(mem_addr) + STEP));

  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(sp) && $stable(bp) && $stable(ip)));
endmodule

bind stk_engine stk_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .sp(sp), .bp(bp), .ip(ip),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/test_stk_engine.sv
module test_stk_engine;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TOS        = 32'h0000_0400;
  localparam logic [31:0] RV         = 32'h0000_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_opnd = '0, cmd_ip = '0;
  logic [31:0] sp, bp, ip, pop_data;
  logic        busy, done;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [31:0] mem [64];
  int stall = 0, wcnt = 0, acc_cnt = 0;
  int checks = 0, errors = 0, cycles = 0;
  int lat = 0;
  bit sp_moved = 0, ready_seen = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stk_engine #(.DW(32), .TOS(TOS), .RST_VEC(RV)) i_stk_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_opnd(cmd_opnd), .cmd_ip(cmd_ip),
    .sp(sp), .bp(bp), .ip(ip), .pop_data(pop_data), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req) begin
      if (wcnt >= stall) begin
        wcnt = 0;
        mem_ack = 1'b1;
        acc_cnt++;
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[7:2]];
      end else begin
        wcnt++;
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] opnd, input logic [31:0] ipv);
    logic [31:0] sp0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_opnd = opnd; cmd_ip = ipv;
    sp0 = sp;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0; sp_moved = 0; ready_seen = 0;
    while (!done) begin
      if (sp !== sp0) sp_moved = 1;
      if (cmd_ready) ready_seen = 1;
      lat++;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R2 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sp", sp, TOS);
    chk("R1 bp", bp, TOS);
    chk("R1 ip", ip, RV);
    chk("R1 busy/done/req", {29'b0, busy, done, mem_req}, 32'd0);
    chk("R1 ready", {31'b0, cmd_ready}, 32'd1);
  endtask

  task automatic t_push_pop();
    run(3'd0, 32'hAAAA_0001, '0);
    chk("R4 sp after push", sp, TOS - 4);
    chk("R4 stored word", mem[(TOS - 4) >> 2 & 63], 32'hAAAA_0001);
    chk("R2 latency no stall", lat, 32'd1);
    run(3'd0, 32'hBBBB_0002, '0);
    chk("R4 second push sp", sp, TOS - 8);
    run(3'd1, '0, '0);
    chk("R5 lifo first", pop_data, 32'hBBBB_0002);
    chk("R5 sp after pop", sp, TOS - 4);
    run(3'd1, '0, '0);
    chk("R5 lifo second", pop_data, 32'hAAAA_0001);
    chk("R5 sp restored", sp, TOS);
  endtask

  task automatic t_frame();
    run(3'd2, 32'h0000_2000, 32'h0000_0123);
    chk("R6 ip target", ip, 32'h0000_2000);
    chk("R6 sp", sp, TOS - 4);
    chk("R6 return addr", mem[(TOS - 4) >> 2 & 63], 32'h0000_0123);
    run(3'd4, '0, '0);
    chk("R8 bp", bp, TOS - 8);
    chk("R8 sp equals bp", sp, TOS - 8);
    chk("R8 saved bp at bp", mem[bp[7:2]], TOS);
    chk("R8 return addr at bp+4", mem[bp[7:2] + 6'd1], 32'h0000_0123);
    run(3'd0, 32'hCCCC_0003, '0);
    run(3'd5, '0, '0);
    chk("R9 sp", sp, TOS - 4);
    chk("R9 bp restored", bp, TOS);
    chk("R9 pop_data", pop_data, TOS);
    run(3'd3, '0, '0);
    chk("R7 ip", ip, 32'h0000_0123);
    chk("R7 sp", sp, TOS);
    chk("R7 pop_data", pop_data, 32'h0000_0123);
  endtask

  task automatic t_stall();
    stall = 3;
    run(3'd0, 32'hDDDD_0004, '0);
    chk("R10 latency with stall", lat, 32'd4);
    chk("R10 sp held while stalled", {31'b0, sp_moved}, 32'd0);
    chk("R2 not ready while busy", {31'b0, ready_seen}, 32'd0);
    chk("R10 sp after stall", sp, TOS - 4);
    run(3'd1, '0, '0);
    chk("R10 pop after stall", pop_data, 32'hDDDD_0004);
    stall = 0;
  endtask

  task automatic t_unknown();
    int a0;
    logic [31:0] sp0, bp0, ip0, pd0;
    a0 = acc_cnt; sp0 = sp; bp0 = bp; ip0 = ip; pd0 = pop_data;
    run(3'd6, 32'h1234_5678, 32'h0000_0777);
    chk("R11 latency", lat, 32'd0);
    run(3'd7, 32'h1234_5678, 32'h0000_0777);
    chk("R11 no access", acc_cnt - a0, 32'd0);
    chk("R11 sp", sp, sp0);
    chk("R11 bp", bp, bp0);
    chk("R11 ip", ip, ip0);
    chk("R11 pop_data", pop_data, pd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_push_pop();
    t_frame();
    t_stall();
    t_unknown();
    finish_run();
  end
endmodule